// File: doc/BRIEF.md
# Sleep Entry and Wake Sequencer

This block moves a system between full-on operation and its sleep depths. Software picks a depth with a 3-bit sleep code and fires a one-cycle go strobe. The sequencer then raises an idle request toward the processor clock controller and waits for the stop-grant acknowledge. Only after that acknowledge does it drive the active-low power-control outputs that belong to the chosen depth. The strobe is a pulse, so nothing is left set once a sequence has begun.

There is a second way in. If the power button is held without a break for longer than the hold window, the block forces the soft-off depth. This path skips the stop-grant wait and needs nothing but the slow real-time tick, which enters as a one-cycle enable pulse. Once a sleep depth is reached, an enabled wake source or a press of the power button brings the system back to full-on and sets a sticky wake flag. After a forced soft-off, the button is the only source that can wake the system.

Top module: `sleep_seq`

## Requirements
- R1: After reset, all three power-control outputs are high, the idle request is low and the wake flag is low.
- R2: In full-on, a go strobe with sleep code 1, 3, 4 or 5 raises the idle request on the next cycle and leaves the power outputs high. Codes 0, 2, 6 and 7 change nothing.
- R3: While the idle request is high, the power outputs stay high. In the cycle after stop-grant is sampled high, the idle request drops and the outputs for the chosen depth are driven.
- R4: The outputs follow the depth. Code 1 drives only `cpu_sleep_n_o` low. Code 3 drives only `aux_pwr_off_n_o` low. Codes 4 and 5 drive both `aux_pwr_off_n_o` and `mem_pwr_off_n_o` low.
- R5: Suppose the button is held on every cycle and `HOLD_TICKS`+1 tick pulses are seen, while the block is in full-on or waiting for stop-grant. On the cycle after the last tick, both aux and mem outputs go low and `cpu_sleep_n_o` stays high. No stop-grant is needed.
- R6: Any cycle with the button released sets the hold count back to zero.
- R7: While asleep, a wake source whose enable bit is set returns the block to full-on on the next cycle. That releases all outputs and sets the wake flag. A wake source whose enable is clear has no effect.
- R8: While asleep, a power-button press wakes the block whatever the enables are set to. A press is the button being high in a cycle where it was low in the cycle before.
- R9: After a forced soft-off, every `wake_src_i` bit is ignored, even when enabled. Only a button press wakes the block.
- R10: The wake flag holds until `wake_flag_clr_i` is high. A new wake in the same cycle as a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| rtc_tick_i | input | 1 | One-cycle pulse at the real-time rate |
| pbtn_i | input | 1 | Power button, high while pressed |
| sleep_code_i | input | 3 | Requested sleep depth code |
| sleep_go_i | input | 1 | One-cycle sleep start strobe |
| stop_grant_i | input | 1 | Processor stop-grant acknowledge |
| wake_src_i | input | N_WAKE | Wake events (alarm, ring, audio) |
| wake_en_i | input | N_WAKE | Per-source wake enables |
| wake_flag_clr_i | input | 1 | Write-1 clear of the wake flag |
| idle_req_o | output | 1 | Idle (stop-clock) request to the processor |
| cpu_sleep_n_o | output | 1 | Processor sleep, active low |
| aux_pwr_off_n_o | output | 1 | Non-critical power off, active low |
| mem_pwr_off_n_o | output | 1 | Memory power off, active low |
| wake_flag_o | output | 1 | Sticky wake status |

## Verification
Every result of this block is due exactly one clock after the input that causes it. The idle request follows the go strobe by one cycle. The sleep outputs follow the sampled stop-grant, or the final tick of a continuous hold, by one cycle. Release of the outputs and the wake flag follow the sampled wake event by one cycle. The bench changes inputs a quarter period after a rising edge and reads outputs after the very next edge, so each check looks at the first cycle in which the result is due. Timer boundaries are checked on both sides: no change after `HOLD_TICKS` ticks, the forced soft-off after one tick more.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;

   typedef enum logic [1:0] {
      ST_ON    = 2'd0,
      ST_IDLE  = 2'd1,
      ST_SLEEP = 2'd2
   } seq_state_e;

   typedef enum logic [1:0] {
      DP_CPU = 2'd0,
      DP_AUX = 2'd1,
      DP_OFF = 2'd2
   } depth_e;

   localparam int unsigned CODE_W = 3;

   function automatic logic code_valid(input logic [CODE_W-1:0] c);
      return (c == 3'd1) || (c == 3'd3) || (c == 3'd4) || (c == 3'd5);
   endfunction

   function automatic depth_e code_depth(input logic [CODE_W-1:0] c);
      depth_e d;
      case (c)
         3'd1:    d = DP_CPU;
         3'd3:    d = DP_AUX;
         default: d = DP_OFF;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/hold_timer.sv
module hold_timer #(
   parameter int unsigned HOLD_TICKS = 131072
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic btn_i,
   input  logic tick_i,
   output logic fire_o
);
   localparam int unsigned CW = $clog2(HOLD_TICKS + 1);
   localparam logic [CW-1:0] LIMIT = CW'(HOLD_TICKS);

   if (HOLD_TICKS < 2) begin : g_bad_hold
      $error("hold_timer: HOLD_TICKS must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (!btn_i) begin
         cnt_q <= '0;
      end else if (tick_i && (cnt_q != LIMIT)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign fire_o = btn_i & tick_i & (cnt_q == LIMIT);

   // R6
   release_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !btn_i |=> (cnt_q == '0));

   // R5
   cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= LIMIT);

   // R5
   fire_needs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire_o |-> $past(btn_i));

endmodule

// File: rtl/wake_gate.sv
module wake_gate #(
   parameter int unsigned N_WAKE = 3
) (
   input  logic [N_WAKE-1:0] src_i,
   input  logic [N_WAKE-1:0] en_i,
   input  logic              lock_i,
   input  logic              press_i,
   output logic              hit_o
);
   if (N_WAKE < 1) begin : g_bad_n
      $error("wake_gate: N_WAKE must be at least 1");
   end

   logic [N_WAKE-1:0] gated;

   for (genvar i = 0; i < N_WAKE; i++) begin : g_src
      assign gated[i] = src_i[i] & en_i[i];
   end

   assign hit_o = press_i | (~lock_i & (|gated));

endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
   import sleep_seq_pkg::*;
(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [CODE_W-1:0] code_i,
   input  logic              go_i,
   input  logic              stop_grant_i,
   input  logic              ovr_fire_i,
   input  logic              wake_hit_i,
   input  logic              flag_clr_i,
   output logic              idle_req_o,
   output logic              cpu_sleep_n_o,
   output logic              aux_off_n_o,
   output logic              mem_off_n_o,
   output logic              flag_o,
   output logic              lock_o
);
   seq_state_e state_q, state_d;
   depth_e     depth_q, depth_d;
   logic       lock_q, lock_d;
   logic       flag_q, flag_set;

   always_comb begin
      state_d  = state_q;
      depth_d  = depth_q;
      lock_d   = lock_q;
      flag_set = 1'b0;
      case (state_q)
         ST_ON: begin
            if (ovr_fire_i) begin
               state_d = ST_SLEEP;
               depth_d = DP_OFF;
               lock_d  = 1'b1;
            end else if (go_i && code_valid(code_i)) begin
               state_d = ST_IDLE;
               depth_d = code_depth(code_i);
            end
         end
         ST_IDLE: begin
            if (ovr_fire_i) begin
               state_d = ST_SLEEP;
               depth_d = DP_OFF;
               lock_d  = 1'b1;
            end else if (stop_grant_i) begin
               state_d = ST_SLEEP;
            end
         end
         ST_SLEEP: begin
            if (wake_hit_i) begin
               state_d  = ST_ON;
               lock_d   = 1'b0;
               flag_set = 1'b1;
            end
         end
         default: begin
            state_d = ST_ON;
            lock_d  = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q <= ST_ON;
         depth_q <= DP_CPU;
         lock_q  <= 1'b0;
         flag_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         depth_q <= depth_d;
         lock_q  <= lock_d;
         flag_q  <= flag_set | (flag_q & ~flag_clr_i);
      end
   end

   assign idle_req_o    = (state_q == ST_IDLE);
   assign cpu_sleep_n_o = ~((state_q == ST_SLEEP) && (depth_q == DP_CPU));
   assign aux_off_n_o   = ~((state_q == ST_SLEEP) && (depth_q != DP_CPU));
   assign mem_off_n_o   = ~((state_q == ST_SLEEP) && (depth_q == DP_OFF));
   assign flag_o        = flag_q;
   assign lock_o        = lock_q;

   // R2
   go_to_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_ON) && go_i && code_valid(code_i) && !ovr_fire_i
      |=> idle_req_o && aux_off_n_o && cpu_sleep_n_o && mem_off_n_o);

   // R2
   bad_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_ON) && go_i && !code_valid(code_i) && !ovr_fire_i
      |=> !idle_req_o && aux_off_n_o && cpu_sleep_n_o);

   // R3
   wait_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      idle_req_o && !stop_grant_i && !ovr_fire_i
      |=> idle_req_o && aux_off_n_o && cpu_sleep_n_o && mem_off_n_o);

   // R5
   forced_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovr_fire_i && (state_q != ST_SLEEP)
      |=> !aux_off_n_o && !mem_off_n_o && cpu_sleep_n_o && !idle_req_o);

   // R7
   wake_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_SLEEP) && wake_hit_i
      |=> aux_off_n_o && cpu_sleep_n_o && mem_off_n_o && flag_o);

   // R10
   flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flag_o && !flag_clr_i |=> flag_o);

   // R4
   depth_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cpu_sleep_n_o |-> aux_off_n_o && mem_off_n_o);

endmodule

// File: rtl/sleep_seq.sv
module sleep_seq
   import sleep_seq_pkg::*;
#(
   parameter int unsigned HOLD_TICKS = 131072,
   parameter int unsigned N_WAKE     = 3
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              rtc_tick_i,
   input  logic              pbtn_i,
   input  logic [2:0]        sleep_code_i,
   input  logic              sleep_go_i,
   input  logic              stop_grant_i,
   input  logic [N_WAKE-1:0] wake_src_i,
   input  logic [N_WAKE-1:0] wake_en_i,
   input  logic              wake_flag_clr_i,
   output logic              idle_req_o,
   output logic              cpu_sleep_n_o,
   output logic              aux_pwr_off_n_o,
   output logic              mem_pwr_off_n_o,
   output logic              wake_flag_o
);
   logic btn_q;
   logic press;
   logic ovr_fire;
   logic wake_hit;
   logic lock;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) btn_q <= 1'b0;
      else         btn_q <= pbtn_i;
   end

   assign press = pbtn_i & ~btn_q;

   hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_timer (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .btn_i  (pbtn_i),
      .tick_i (rtc_tick_i),
      .fire_o (ovr_fire)
   );

   wake_gate #(.N_WAKE(N_WAKE)) u_gate (
      .src_i   (wake_src_i),
      .en_i    (wake_en_i),
      .lock_i  (lock),
      .press_i (press),
      .hit_o   (wake_hit)
   );

   sleep_fsm u_fsm (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .code_i        (sleep_code_i),
      .go_i          (sleep_go_i),
      .stop_grant_i  (stop_grant_i),
      .ovr_fire_i    (ovr_fire),
      .wake_hit_i    (wake_hit),
      .flag_clr_i    (wake_flag_clr_i),
      .idle_req_o    (idle_req_o),
      .cpu_sleep_n_o (cpu_sleep_n_o),
      .aux_off_n_o   (aux_pwr_off_n_o),
      .mem_off_n_o   (mem_pwr_off_n_o),
      .flag_o        (wake_flag_o),
      .lock_o        (lock)
   );

   // R9
   locked_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lock && !mem_pwr_off_n_o && !press |=> !mem_pwr_off_n_o);

   // R8
   press_wakes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !aux_pwr_off_n_o && press |=> aux_pwr_off_n_o && wake_flag_o);

endmodule

// File: tb/sleep_seq_tb_top.sv
module sleep_seq_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int HOLD       = 16;
   localparam int NW         = 3;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          tick, btn, go, grant, clr;
   logic [2:0]    code;
   logic [NW-1:0] src, en;
   logic          idle, cpu_n, aux_n, mem_n, flag;

   int n_chk  = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sleep_seq #(.HOLD_TICKS(HOLD), .N_WAKE(NW)) dut_i (
      .clk_i           (clk),
      .rst_ni          (rst_n),
      .rtc_tick_i      (tick),
      .pbtn_i          (btn),
      .sleep_code_i    (code),
      .sleep_go_i      (go),
      .stop_grant_i    (grant),
      .wake_src_i      (src),
      .wake_en_i       (en),
      .wake_flag_clr_i (clr),
      .idle_req_o      (idle),
      .cpu_sleep_n_o   (cpu_n),
      .aux_pwr_off_n_o (aux_n),
      .mem_pwr_off_n_o (mem_n),
      .wake_flag_o     (flag)
   );

   function automatic bit valid_code(input logic [2:0] c);
      return (c == 3'd1) || (c == 3'd3) || (c == 3'd4) || (c == 3'd5);
   endfunction

   function automatic logic [2:0] exp_pins(input logic [2:0] c);
      case (c)
         3'd1:       return 3'b011;
         3'd3:       return 3'b101;
         3'd4, 3'd5: return 3'b100;
         default:    return 3'b111;
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      #(CLK_PERIOD/4);
   endtask

   task automatic ticks(input int n);
      for (int k = 0; k < n; k++) begin
         tick = 1'b1; cyc();
         tick = 1'b0; cyc();
      end
   endtask

   task automatic press_wake(input string req);
      btn = 1'b0; cyc();
      btn = 1'b1; cyc();
      check(req, {cpu_n, aux_n, mem_n, flag}, 4'b1111);
      btn = 1'b0; clr = 1'b1; cyc();
      clr = 1'b0;
      check("R10", flag, 1'b0);
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      report();
   end

   initial begin
      logic [31:0] seed;
      seed = $urandom(32'h51EE_2A11);
      rst_n = 1'b0; tick = 0; btn = 0; go = 0; grant = 0; clr = 0;
      code = '0; src = '0; en = '0;
      repeat (3) cyc();
      rst_n = 1'b1; cyc();
      // R1 reset state
      check("R1", {idle, cpu_n, aux_n, mem_n, flag}, 5'b01110);

      // R2, R3, R4, R7, R8, R10: random depth, delay, wake source and enables
      for (int i = 0; i < 40; i++) begin
         logic [2:0] c;
         int dly, s;
         c = 3'($urandom % 8);
         code = c; go = 1'b1; cyc(); go = 1'b0;
         if (!valid_code(c)) begin
            check("R2", {idle, cpu_n, aux_n, mem_n}, 4'b0111);
            continue;
         end
         check("R2", {idle, cpu_n, aux_n, mem_n}, 4'b1111);
         dly = int'($urandom % 4);
         for (int d = 0; d < dly; d++) cyc();
         check("R3", {idle, cpu_n, aux_n, mem_n}, 4'b1111);
         grant = 1'b1; cyc(); grant = 1'b0;
         check("R4", {idle, cpu_n, aux_n, mem_n}, {1'b0, exp_pins(c)});
         s  = int'($urandom % NW);
         en = NW'($urandom);
         src = NW'(1) << s; cyc(); src = '0;
         if (en[s]) begin
            check("R7", {cpu_n, aux_n, mem_n, flag}, 4'b1111);
            cyc();
            check("R10", flag, 1'b1);
            clr = 1'b1; cyc(); clr = 1'b0;
            check("R10", flag, 1'b0);
         end else begin
            check("R7", {cpu_n, aux_n, mem_n, flag}, {exp_pins(c), 1'b0});
            press_wake("R8");
         end
      end

      // R10 wake and clear in the same cycle: set wins
      code = 3'd3; go = 1'b1; cyc(); go = 1'b0;
      grant = 1'b1; cyc(); grant = 1'b0;
      en = 3'b111; src = 3'b001; clr = 1'b1; cyc(); src = '0; clr = 1'b0;
      check("R10", flag, 1'b1);
      clr = 1'b1; cyc(); clr = 1'b0;

      // R5, R9 forced soft-off from full-on
      en = 3'b111;
      btn = 1'b1; cyc();
      ticks(HOLD);
      check("R5", {cpu_n, aux_n, mem_n}, 3'b111);
      tick = 1'b1; cyc(); tick = 1'b0;
      check("R5", {idle, cpu_n, aux_n, mem_n}, 4'b0100);
      src = 3'b111; cyc(); src = '0;
      check("R9", {cpu_n, aux_n, mem_n, flag}, 4'b1000);
      press_wake("R9");

      // R5 forced soft-off while waiting for stop-grant
      code = 3'd1; go = 1'b1; cyc(); go = 1'b0;
      check("R2", idle, 1'b1);
      btn = 1'b1; cyc();
      ticks(HOLD + 1);
      check("R5", {idle, cpu_n, aux_n, mem_n}, 4'b0100);
      press_wake("R8");

      // R6 a release restarts the hold window
      btn = 1'b1; cyc();
      ticks(10);
      btn = 1'b0; cyc();
      btn = 1'b1; cyc();
      ticks(10);
      check("R6", {cpu_n, aux_n, mem_n}, 3'b111);
      ticks(7);
      check("R6", {cpu_n, aux_n, mem_n}, 3'b100);
      press_wake("R8");

      report();
   end
endmodule